// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Bank

This block derives four clock-enable pulse streams from a single fast clock. The four domains are a bus domain, a coherency-port domain, a trace domain and a debug-APB domain. Each domain has an integer divider. Its output is a one-cycle enable pulse that repeats once every (programmed value + 1) source cycles. Logic in each domain runs on the fast clock and qualifies its flops with that enable, so no second clock tree is needed.

Software loads divider values through a small write port, and each value is first held as pending. None of the dividers changes until a change-trigger strobe is written. On the trigger, all four dividers take their pending values in the same cycle and restart their phase together. A 2-bit enable-select field per domain gates that domain's pulses; only the value 3 lets them through. Typical settings are 1, 1, 4 and 11, which give ratios 2, 2, 5 and 12.

Top module: `clkdiv_bank`

## Requirements
- R1: Right after reset every enable output is low, every divider runs at ratio 1, and every enable-select field is 0.
- R2: Once a value v is applied, the domain's enable pulses exactly once every v+1 cycles, as long as the domain is switched on.
- R3: Writing address d (0 = bus, 1 = coherency port, 2 = trace, 3 = debug APB) stores wr_data[7:0] as that domain's pending value. The value has no effect on any output until a trigger is applied.
- R4: Writing address 5 with wr_data[0] = 1 is the trigger. If that write is captured at clock edge k, then at edge k+1 all four dividers load their pending values and restart at phase 0. Every enabled domain pulses in the cycle after edge k+1.
- R5: An applied value of 0 (ratio 1) holds the enable of a switched-on domain high in every cycle.
- R6: Address 4 holds the enable-select fields, with domain d in wr_data[2d+1:2d]. Only the code 3 passes that domain's pulses; the codes 0, 1 and 2 hold it low. A change of enable-select neither restarts nor shifts any divider phase.
- R7: The trigger clears itself one cycle after it is applied. A later pending write therefore stays without effect, and a write of 0 to address 5 does not restart anything.
- R8: Writes to addresses 6 and 7 have no effect on any output.
- R9: At any ratio above 1, each enable pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register address (0-3 divider values, 4 enable-select, 5 trigger) |
| wr_data | input | 16 | Write data |
| clk_en_o | output | 4 | One-cycle enable pulse per domain, bit d for domain d |

## Verification
The assertions assume that no two trigger writes arrive on consecutive cycles. They also assume that no pending value is written in the same cycle that a trigger takes effect. Under either of those, the self-clear and restart properties would not hold as written. The stimulus keeps within these limits because every write is followed by a cycle with the strobe low, and each trigger is issued on its own, apart from the divider writes. A bench-side reference model follows only the writes it drives and predicts each domain's expected phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam logic [1:0] SEL_RUN = 2'b11;

  function automatic int unsigned div_ratio(input int unsigned value);
    return value + 1;
  endfunction

  function automatic logic sel_passes(input logic [1:0] field);
    return field == SEL_RUN;
  endfunction

endpackage

// File: rtl/cdb_regs.sv
module cdb_regs #(
  parameter int NUM_DOM = 4,
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_DOM*DIV_W-1:0]   pend_flat,
  output logic [2*NUM_DOM-1:0]       sel_flat,
  output logic                       apply_o
);

  localparam int SEL_ADDR  = NUM_DOM;
  localparam int TRIG_ADDR = NUM_DOM + 1;
  localparam int SEL_W     = 2 * NUM_DOM;

  wire unused_data = ^wr_data;

  logic sel_hit;
  logic trig_hit;

  assign sel_hit  = wr_en && (wr_addr == ADDR_W'(SEL_ADDR));
  assign trig_hit = wr_en && (wr_addr == ADDR_W'(TRIG_ADDR)) && wr_data[0];

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_pend
    logic [DIV_W-1:0] pend_q;
    logic             hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend_q <= '0;
      else if (hit) pend_q <= wr_data[DIV_W-1:0];
    end
    assign pend_flat[d*DIV_W +: DIV_W] = pend_q;
  end

  logic [SEL_W-1:0] sel_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (sel_hit) sel_q <= wr_data[SEL_W-1:0];
  end
  assign sel_flat = sel_q;

  logic trig_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_hit;
  end
  assign apply_o = trig_q;

endmodule

// File: rtl/cdb_divider.sv
module cdb_divider
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic [DIV_W-1:0] pend_val,
  input  logic [1:0]       sel,
  output logic             en_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] active_o
);

  logic [DIV_W-1:0] active_q;
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;
  logic             tick;

  assign wrap = (cnt_q == active_q);
  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      cnt_q    <= '0;
    end else if (apply) begin
      active_q <= pend_val;
      cnt_q    <= '0;
    end else if (wrap) begin
      cnt_q    <= '0;
    end else begin
      cnt_q    <= cnt_q + DIV_W'(1);
    end
  end

  assign en_o     = tick && sel_passes(sel);
  assign cnt_o    = cnt_q;
  assign active_o = active_q;

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int NUM_DOM = 4,
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_DOM-1:0] clk_en_o
);

  logic [NUM_DOM*DIV_W-1:0] pend_flat;
  logic [NUM_DOM*DIV_W-1:0] cnt_flat;
  logic [NUM_DOM*DIV_W-1:0] active_flat;
  logic [2*NUM_DOM-1:0]     sel_flat;
  logic                     apply_w;

  cdb_regs #(
    .NUM_DOM(NUM_DOM), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pend_flat(pend_flat),
    .sel_flat (sel_flat),
    .apply_o  (apply_w)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_div
    cdb_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply   (apply_w),
      .pend_val(pend_flat[d*DIV_W +: DIV_W]),
      .sel     (sel_flat[2*d +: 2]),
      .en_o    (clk_en_o[d]),
      .cnt_o   (cnt_flat[d*DIV_W +: DIV_W]),
      .active_o(active_flat[d*DIV_W +: DIV_W])
    );
  end

endmodule

// File: rtl/cdb_checker.sv
module cdb_checker #(
  parameter int NUM_DOM = 4,
  parameter int DIV_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     apply,
  input logic [NUM_DOM-1:0]       en,
  input logic [NUM_DOM*DIV_W-1:0] cnt_flat,
  input logic [NUM_DOM*DIV_W-1:0] active_flat,
  input logic [2*NUM_DOM-1:0]     sel_flat
);

  AST_TRIG_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !apply); // R7

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (cnt_flat == '0)); // R4

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(active_flat)); // R3

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[d*DIV_W +: DIV_W] <= active_flat[d*DIV_W +: DIV_W]); // R2

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (en[d] && (active_flat[d*DIV_W +: DIV_W] != '0) && !apply) |=> !en[d]); // R9

    AST_ZERO_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
      ((active_flat[d*DIV_W +: DIV_W] == '0) && (sel_flat[2*d +: 2] == 2'b11)) |-> en[d]); // R5
  end

endmodule

bind clkdiv_bank cdb_checker #(.NUM_DOM(NUM_DOM), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .apply      (apply_w),
  .en         (clk_en_o),
  .cnt_flat   (cnt_flat),
  .active_flat(active_flat),
  .sel_flat   (sel_flat)
);

// File: tb/clkdiv_bank_test.sv
module clkdiv_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  clk_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  clkdiv_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .clk_en_o(clk_en_o)
  );

  always #2ns clk = ~clk;

  // Reference model driven only by the writes the bench issues.
  int       phase;
  int       ratio_m [4];
  int       pend_m  [4];
  logic [7:0] sel_m;
  bit       trig_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; sel_m = '0; trig_m = 1'b0;
      for (int d = 0; d < 4; d++) begin ratio_m[d] = 1; pend_m[d] = 0; end
    end else begin
      if (trig_m) begin
        phase = 0;
        for (int d = 0; d < 4; d++) ratio_m[d] = pend_m[d] + 1;
      end else begin
        phase = phase + 1;
      end
      trig_m = wr_en && (wr_addr == 3'd5) && wr_data[0];
      if (wr_en && wr_addr < 3'd4) pend_m[int'(wr_addr)] = int'(wr_data[7:0]);
      if (wr_en && wr_addr == 3'd4) sel_m = wr_data[7:0];
    end
  end

  function automatic logic [3:0] expected_en();
    logic [3:0] e;
    for (int d = 0; d < 4; d++)
      e[d] = (sel_m[2*d +: 2] == 2'b11) && ((phase % ratio_m[d]) == 0);
    return e;
  endfunction

  task automatic check_val(input string tag, input logic [3:0] exp);
    checks++;
    if (clk_en_o !== exp) begin
      fails++;
      $display("FAIL %s: clk_en_o actual %b expected %b", tag, clk_en_o, exp);
    end
  endtask

  task automatic check_span(input int n, input string tag);
    bit bad = 1'b0;
    checks++;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!bad && clk_en_o !== expected_en()) begin
        bad = 1'b1;
        fails++;
        $display("FAIL %s: cycle %0d clk_en_o actual %b expected %b",
                 tag, i, clk_en_o, expected_en());
      end
    end
  endtask

  task automatic write(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    #1ns;
    check_val("R1 in reset", 4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R1 after reset", 4'b0000);
    check_span(5, "R1 disabled idle");
  endtask

  task automatic t_ratio_one();
    write(3'd4, 16'h00FF);
    check_span(8, "R5 reset ratio every cycle");
  endtask

  task automatic t_pending_hold();
    write(3'd0, 16'd1);
    write(3'd1, 16'd1);
    write(3'd2, 16'd4);
    write(3'd3, 16'd11);
    check_span(6, "R3 pending not applied");
  endtask

  task automatic t_trigger();
    write(3'd5, 16'h0001);
    @(negedge clk);
    check_val("R4 all pulse after apply", 4'b1111);
    @(negedge clk);
    check_val("R9 one-cycle pulse", 4'b0000);
    check_span(60, "R2 ratios 2 2 5 12");
  endtask

  task automatic t_zero();
    write(3'd0, 16'd2);
    write(3'd1, 16'd0);
    write(3'd2, 16'd6);
    write(3'd3, 16'd3);
    write(3'd5, 16'h0001);
    @(negedge clk);
    check_val("R4 restart second trigger", 4'b1111);
    check_span(40, "R5 zero value mixed");
  endtask

  task automatic t_gate();
    write(3'd4, 16'h0027);
    check_span(30, "R6 codes 1 2 0 hold low");
    write(3'd4, 16'h00FF);
    check_span(30, "R6 phase kept after reenable");
  endtask

  task automatic t_self_clear();
    write(3'd5, 16'h0000);
    check_span(10, "R7 zero trigger no restart");
    write(3'd0, 16'd7);
    write(3'd2, 16'd1);
    check_span(25, "R7 later pending stays idle");
  endtask

  task automatic t_unused();
    write(3'd6, 16'hFFFF);
    write(3'd7, 16'h0001);
    check_span(20, "R8 unused addresses");
  endtask

  task automatic t_long_ratio();
    write(3'd3, 16'd11);
    write(3'd5, 16'h0001);
    check_span(50, "R9 and R2 after new trigger");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ratio_one();
    t_pending_hold();
    t_trigger();
    t_zero();
    t_gate();
    t_self_clear();
    t_unused();
    t_long_ratio();
    finish_run();
  end

  initial begin
    #400us;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule